// File: doc/BRIEF.md
# Power-Request Interrupt Unit

This unit sits on the register side of an SD host controller and turns host writes into power-sequencing requests. It has a private copy of three host-visible controls: the bus-power bit, the 1.8 V signalling select bit and the software-reset request bit. It compares each host write against the state it already holds. A write that changes a watched control posts one of four request kinds (bus on, bus off, I/O high voltage, I/O low voltage) as a sticky status bit and raises an interrupt. A write that leaves a control unchanged posts nothing. Firmware services each request kind by writing its bit to an acknowledge register.

The unit also drives the regulator enable for card bus power and the pad power-switch control. The pad control selects low-voltage pad mode while 1.8 V signalling is chosen. A static capability strap turns switchable signalling on or off. When the strap is low, the signalling select stays at 3.3 V and its requests never fire. Register offsets, bit positions and the address width are parameters. A parameter can also add an output register on the interrupt line.

Top module: `pwr_req_irq_unit`

## Requirements
- R1: After reset the status vector is 0, the interrupt mask is all ones, and the interrupt, bus-power enable and pad low-voltage outputs are all low.
- R2: A write to the power register (offset 0) whose bit 0 differs from the held bus-power state sets status bit 0 (bus on) when the new value is 1, or status bit 1 (bus off) when it is 0. A write with an unchanged bit 0 sets no status. The bus-power enable output shows the written bit in the cycle after the write.
- R3: With the capability strap high, a write to the host-control-2 register (offset 1) whose bit 3 differs from the held select state sets status bit 3 (I/O low) on 0→1 or status bit 2 (I/O high) on 1→0. The pad low-voltage output follows bit 3 in the next cycle. Writing 0 while the select is already 0 sets nothing.
- R4: With the capability strap low, writes to the host-control-2 register have no effect: no status is set and the pad low-voltage output stays low.
- R5: A write to the reset register (offset 2) with bit 1 set always sets status bit 1. It also sets status bit 2 if the select was at 1.8 V. It then returns both the bus-power enable and the pad low-voltage output to low. A write to that register with bit 1 clear has no effect.
- R6: A write to the acknowledge register (offset 3) clears each status bit whose data bit 0 to 3 is 1. It leaves the other status bits unchanged.
- R7: A repeat event of a kind whose status is still pending leaves that bit set and queues nothing. A single acknowledge of that bit clears it.
- R8: The interrupt output is high exactly when some status bit is set and its bit in the mask register (offset 4, data bits 0 to 3, written whole) is 1. With the default of no output register it follows in the same cycle as the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_switch_en | input | 1 | Switchable-signalling capability strap, static outside reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | ADDR_W | Register offset of the write |
| wr_data | input | DATA_W | Write data |
| irq | output | 1 | Power request interrupt |
| irq_status | output | 4 | Pending requests: bit0 bus on, bit1 bus off, bit2 I/O high, bit3 I/O low |
| bus_pwr_en | output | 1 | Regulator enable for card bus power |
| io_low_en | output | 1 | Pad power-switch control, high selects low-voltage pads |

## Verification
The bench builds the unit with its default parameters: a 3-bit address, 32-bit data, the watched bits at positions 0, 3 and 1, and no interrupt output register. With these values the interrupt is visible in the same cycle as the status, so one sample per write compares the whole output vector. The small operation alphabet allows every ordered triple of writes to run from reset, with the capability strap both high and low. This reaches every pairing of held state, repeated request, acknowledge and software reset. A sweep of all sixteen mask values over a fully pending status and a directed repeat-request sequence complete the set.

// File: rtl/pwr_req_pkg.sv
package pwr_req_pkg;
   localparam int NUM_REQ     = 4;
   localparam int REQ_BUS_ON  = 0;
   localparam int REQ_BUS_OFF = 1;
   localparam int REQ_IO_HIGH = 2;
   localparam int REQ_IO_LOW  = 3;
   typedef logic [NUM_REQ-1:0] req_vec_t;
endpackage

// File: rtl/pwr_req_decode.sv
module pwr_req_decode
   import pwr_req_pkg::*;
#(
   parameter int ADDR_W   = 3,
   parameter int DATA_W   = 32,
   parameter int PWR_ADDR = 0,
   parameter int HC2_ADDR = 1,
   parameter int RST_ADDR = 2,
   parameter int ACK_ADDR = 3,
   parameter int MSK_ADDR = 4,
   parameter int PWR_BIT  = 0,
   parameter int VSEL_BIT = 3,
   parameter int RST_BIT  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output req_vec_t          evt,
   output logic              ack_we,
   output req_vec_t          ack_bits,
   output logic              msk_we,
   output req_vec_t          msk_bits,
   output logic              bus_on_q,
   output logic              io_low_q
);
   logic hit_pwr, hit_hc2, hit_rst;
   logic pwr_new, vsel_new, rst_req, vsel_live;

   always_comb begin
      hit_pwr   = wr_en && (wr_addr == ADDR_W'(PWR_ADDR));
      hit_hc2   = wr_en && (wr_addr == ADDR_W'(HC2_ADDR));
      hit_rst   = wr_en && (wr_addr == ADDR_W'(RST_ADDR));
      ack_we    = wr_en && (wr_addr == ADDR_W'(ACK_ADDR));
      msk_we    = wr_en && (wr_addr == ADDR_W'(MSK_ADDR));
      ack_bits  = wr_data[NUM_REQ-1:0];
      msk_bits  = wr_data[NUM_REQ-1:0];
      pwr_new   = wr_data[PWR_BIT];
      vsel_new  = wr_data[VSEL_BIT];
      rst_req   = hit_rst && wr_data[RST_BIT];
      vsel_live = hit_hc2 && cap_en;
   end

   always_comb begin
      evt              = '0;
      evt[REQ_BUS_ON]  = hit_pwr && pwr_new && !bus_on_q;
      evt[REQ_BUS_OFF] = (hit_pwr && !pwr_new && bus_on_q) || rst_req;
      evt[REQ_IO_HIGH] = (vsel_live && !vsel_new && io_low_q) || (rst_req && io_low_q);
      evt[REQ_IO_LOW]  = vsel_live && vsel_new && !io_low_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_on_q <= 1'b0;
         io_low_q <= 1'b0;
      end else if (rst_req) begin
         bus_on_q <= 1'b0;
         io_low_q <= 1'b0;
      end else begin
         if (hit_pwr)   bus_on_q <= pwr_new;
         if (vsel_live) io_low_q <= vsel_new;
      end
   end

   // R2: a power write that repeats the held value posts no bus request
   a_r2_same_value_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_pwr && (pwr_new == bus_on_q)) |-> !evt[REQ_BUS_ON] && !(evt[REQ_BUS_OFF] && !rst_req));

   // R4: with the capability strap low the select never leaves 3.3 V
   a_r4_select_held: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_en |-> !io_low_q);

   // R3: a select write leaves the held state equal to the written bit
   a_r3_select_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      vsel_live |=> io_low_q == $past(vsel_new));
endmodule

// File: rtl/pwr_req_status.sv
module pwr_req_status
   import pwr_req_pkg::*;
#(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic     clk,
   input  logic     rst_n,
   input  req_vec_t evt,
   input  logic     ack_we,
   input  req_vec_t ack_bits,
   input  logic     msk_we,
   input  req_vec_t msk_bits,
   output req_vec_t status,
   output logic     irq
);
   req_vec_t mask_q;
   logic     irq_raw;

   for (genvar i = 0; i < NUM_REQ; i++) begin : g_req
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     status[i] <= 1'b0;
         else if (evt[i])                status[i] <= 1'b1;
         else if (ack_we && ack_bits[i]) status[i] <= 1'b0;
      end

      // R7: a pending request only drops through its acknowledge bit
      a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (status[i] && !(ack_we && ack_bits[i])) |=> status[i]);

      // R6: an acknowledge without a coincident event clears the bit
      a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
         (ack_we && ack_bits[i] && !evt[i]) |=> !status[i]);

      // R2/R3/R5: an event is visible as pending in the next cycle
      a_r7_event_posts: assert property (@(posedge clk) disable iff (!rst_n)
         evt[i] |=> status[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mask_q <= '1;
      else if (msk_we) mask_q <= msk_bits;
   end

   assign irq_raw = |(status & mask_q);

   if (IRQ_REG) begin : g_irq_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= irq_raw;
      end
   end else begin : g_irq_comb
      assign irq = irq_raw;
   end

   // R8: no pending request means no interrupt once the pipeline has drained
   a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (status == '0 && $past(status == '0)) |-> !irq);
endmodule

// File: rtl/pwr_req_irq_unit.sv
module pwr_req_irq_unit
   import pwr_req_pkg::*;
#(
   parameter int ADDR_W   = 3,
   parameter int DATA_W   = 32,
   parameter int PWR_ADDR = 0,
   parameter int HC2_ADDR = 1,
   parameter int RST_ADDR = 2,
   parameter int ACK_ADDR = 3,
   parameter int MSK_ADDR = 4,
   parameter int PWR_BIT  = 0,
   parameter int VSEL_BIT = 3,
   parameter int RST_BIT  = 1,
   parameter bit IRQ_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_switch_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              irq,
   output logic [3:0]        irq_status,
   output logic              bus_pwr_en,
   output logic              io_low_en
);
   localparam int NUM_REGS = 5;

   if (DATA_W < NUM_REQ) begin : g_chk_dw
      $error("DATA_W must hold the request vector");
   end
   if (PWR_BIT >= DATA_W || VSEL_BIT >= DATA_W || RST_BIT >= DATA_W) begin : g_chk_bits
      $error("watched bit position outside the data word");
   end
   if ((1 << ADDR_W) < NUM_REGS) begin : g_chk_aw
      $error("ADDR_W too small for the register set");
   end
   if (PWR_ADDR == HC2_ADDR || PWR_ADDR == RST_ADDR || PWR_ADDR == ACK_ADDR ||
       PWR_ADDR == MSK_ADDR || HC2_ADDR == RST_ADDR || HC2_ADDR == ACK_ADDR ||
       HC2_ADDR == MSK_ADDR || RST_ADDR == ACK_ADDR || RST_ADDR == MSK_ADDR ||
       ACK_ADDR == MSK_ADDR) begin : g_chk_addr
      $error("register offsets must be distinct");
   end

   req_vec_t evt, ack_bits, msk_bits, status;
   logic     ack_we, msk_we, bus_on_q, io_low_q;

   pwr_req_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .PWR_ADDR(PWR_ADDR), .HC2_ADDR(HC2_ADDR), .RST_ADDR(RST_ADDR),
      .ACK_ADDR(ACK_ADDR), .MSK_ADDR(MSK_ADDR),
      .PWR_BIT(PWR_BIT), .VSEL_BIT(VSEL_BIT), .RST_BIT(RST_BIT)
   ) u_decode (
      .clk(clk), .rst_n(rst_n), .cap_en(cap_switch_en),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .evt(evt), .ack_we(ack_we), .ack_bits(ack_bits),
      .msk_we(msk_we), .msk_bits(msk_bits),
      .bus_on_q(bus_on_q), .io_low_q(io_low_q)
   );

   pwr_req_status #(.IRQ_REG(IRQ_REG)) u_status (
      .clk(clk), .rst_n(rst_n), .evt(evt),
      .ack_we(ack_we), .ack_bits(ack_bits),
      .msk_we(msk_we), .msk_bits(msk_bits),
      .status(status), .irq(irq)
   );

   assign irq_status = status;
   assign bus_pwr_en = bus_on_q;
   assign io_low_en  = io_low_q;

   // R2: regulator enable shows the written power bit one cycle after the write
   a_r2_bus_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(PWR_ADDR)) |=> bus_pwr_en == $past(wr_data[PWR_BIT]));

   // R5: a reset request drops both outputs and leaves bus-off pending
   a_r5_reset_request: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(RST_ADDR) && wr_data[RST_BIT])
      |=> !bus_pwr_en && !io_low_en && irq_status[REQ_BUS_OFF]);

   // R4: select writes leave the pad output low while the strap is low
   a_r4_pad_low: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(HC2_ADDR) && !cap_switch_en) |=> !io_low_en);
endmodule

// File: tb/pwr_req_irq_unit_bench.sv
module pwr_req_irq_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cap = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        irq, bus_pwr_en, io_low_en;
   logic [3:0]  irq_status;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   logic       m_bus, m_io;
   logic [3:0] m_st, m_mask;

   always #2.5 clk = ~clk;

   pwr_req_irq_unit u_pwr_req_irq_unit (
      .clk(clk), .rst_n(rst_n), .cap_switch_en(cap),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .irq(irq), .irq_status(irq_status),
      .bus_pwr_en(bus_pwr_en), .io_low_en(io_low_en)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles >= 150000) begin
         errors++;
         $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic check(input string tag);
      logic [6:0] got, exp;
      got = {irq, irq_status, bus_pwr_en, io_low_en};
      exp = {|(m_st & m_mask), m_st, m_bus, m_io};
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b (irq,status,bus,io)", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic do_reset(input logic c);
      @(negedge clk);
      rst_n = 1'b0; cap = c;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      m_bus = 0; m_io = 0; m_st = 0; m_mask = 4'hF;
      check("R1 reset state");
   endtask

   // operations: 0/1 power bit, 2/3 select bit, 4 reset request, 5 reset reg without bit 1,
   // 6/7 acknowledge patterns
   task automatic do_op(input int op);
      string tag;
      case (op)
         0, 1: begin
            wr(3'd0, 32'(op) | 32'hFFFF_FFF0 * (op % 2));
            if (m_bus != op[0]) m_st |= op[0] ? 4'b0001 : 4'b0010;
            m_bus = op[0];
            tag = "R2 power bit";
         end
         2, 3: begin
            wr(3'd1, (op == 3) ? 32'h0000_0008 : 32'hFFFF_FFF7);
            if (cap && (m_io != (op == 3))) m_st |= (op == 3) ? 4'b1000 : 4'b0100;
            if (cap) m_io = (op == 3);
            tag = cap ? "R3 select bit" : "R4 select ignored";
         end
         4: begin
            wr(3'd2, 32'h0000_0002);
            m_st |= 4'b0010;
            if (m_io) m_st |= 4'b0100;
            m_bus = 0; m_io = 0;
            tag = "R5 reset request";
         end
         5: begin
            wr(3'd2, 32'hFFFF_FFFD);
            tag = "R5 reset bit clear";
         end
         6: begin
            wr(3'd3, 32'h0000_0005);
            m_st &= ~4'b0101;
            tag = "R6 acknowledge";
         end
         default: begin
            wr(3'd3, 32'h0000_000A);
            m_st &= ~4'b1010;
            tag = "R6 acknowledge";
         end
      endcase
      check(tag);
   endtask

   initial begin
      m_bus = 0; m_io = 0; m_st = 0; m_mask = 4'hF;
      for (int c = 0; c < 2; c++) begin
         for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
               for (int d = 0; d < 8; d++) begin
                  do_reset(c[0]);
                  do_op(a);
                  do_op(b);
                  do_op(d);
               end
            end
         end
      end

      // R7: repeated bus-on while pending, then a single acknowledge clears it
      do_reset(1'b1);
      do_op(1); do_op(0); do_op(1);
      wr(3'd3, 32'h0000_0001);
      m_st &= ~4'b0001;
      check("R7 single acknowledge after repeat");

      // R8: sweep every mask over a fully pending status
      do_reset(1'b1);
      do_op(1); do_op(0); do_op(3); do_op(2);
      for (int m = 0; m < 16; m++) begin
         wr(3'd4, 32'(m));
         m_mask = m[3:0];
         check("R8 mask sweep");
      end
      for (int k = 0; k < 4; k++) begin
         wr(3'd3, 32'(1 << k));
         m_st &= ~(4'b0001 << k);
         check("R8 masked clear");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule